// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the current word address of a synchronous memory that runs four-beat bursts. When a new access is accepted, it captures the external address. Each later burst-continue cycle moves it to the next beat. The upper address bits pass through from the captured address unchanged. Only the low two bits step through the burst.

A static order pin picks the stepping rule. With the pin low, the low bits count up by one and wrap within the group of four. With the pin high, the low bits are the captured low bits XORed with a beat index that runs 0, 1, 2, 3. The output is registered, so it shows the effect of a cycle one clock after that cycle's edge.

A deselect cycle ends the burst. Continue cycles that follow a deselect leave the address alone. A high clock-enable freezes everything for that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and after it is released, `addr_o` is zero, and the sequencer is idle, so continue cycles do not move it until a load.
- R2: An edge with `ce_n` low and `load` high sets `addr_o` to `ext_addr` from the next cycle on, and sets the beat index to 0.
- R3: With `lin_n` low, each accepted continue edge sets `addr_o[1:0]` to the previous value plus one, modulo 4. `addr_o[ADDR_W-1:2]` does not change (no carry out of the low field).
- R4: With `lin_n` high, beat k of a burst (k = 0..3, counting from the load) gives `addr_o[1:0]` = loaded low bits XOR k. The upper bits stay equal to the loaded address.
- R5: After four continue edges the address returns to the loaded address, and further continue edges repeat the same four addresses.
- R6: An edge with `ce_n` high changes nothing, whatever `load`, `desel` and `adv` are.
- R7: After a `desel` edge, and before any load, continue edges leave `addr_o` unchanged. `desel` itself keeps the current address.
- R8: A load in the middle of a burst restarts the sequence at the new address with beat index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Clock enable, active low; high stalls the block |
| load | input | 1 | New command with the device selected (capture address) |
| desel | input | 1 | New-command cycle with the device not selected (end burst) |
| adv | input | 1 | Burst-continue cycle |
| lin_n | input | 1 | Order select: low = linear, high = interleaved |
| ext_addr | input | ADDR_W | External address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
A wrong beat index shows up in `addr_o[1:0]` one clock after the continue edge that produced it. In interleaved order, one wrong beat also corrupts every later beat of that burst, so a single walk through four beats exposes it. A lost stall or a lost idle flag shows as an address that moves on the next edge when it should have held. A carry leaking into the upper bits shows on the first wrap from 3 to 0, so the tests use loaded low bits of 2 and 3.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic [2:0] {
        CMD_HOLD  = 3'd0,
        CMD_LOAD  = 3'd1,
        CMD_DESEL = 3'd2,
        CMD_STEP  = 3'd3,
        CMD_IDLE  = 3'd4
    } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic       ce_n,
    input  logic       load,
    input  logic       desel,
    input  logic       adv,
    input  logic       active,
    output burst_cmd_e cmd
);
    always_comb begin
        if (ce_n)                cmd = CMD_HOLD;
        else if (load)           cmd = CMD_LOAD;
        else if (desel)          cmd = CMD_DESEL;
        else if (adv && active)  cmd = CMD_STEP;
        else                     cmd = CMD_IDLE;
    end
endmodule

// File: rtl/burst_state.sv
module burst_state
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  burst_cmd_e         cmd,
    input  logic [ADDR_W-1:0]  ext_addr,
    output logic [ADDR_W-1:0]  base_o,
    output logic [BURST_W-1:0] beat_o,
    output logic               active_o
);
    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] beat;
        logic               active;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (cmd)
            CMD_LOAD: begin
                st_d.base   = ext_addr;
                st_d.beat   = '0;
                st_d.active = 1'b1;
            end
            CMD_DESEL: st_d.active = 1'b0;
            CMD_STEP:  st_d.beat   = st_q.beat + 1'b1;
            default:   st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o   = st_q.base;
    assign beat_o   = st_q.beat;
    assign active_o = st_q.active;

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_HOLD) |=> ($stable(st_q.base) && $stable(st_q.beat) && $stable(st_q.active)));

    // R2
    load_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> (st_q.base == $past(ext_addr) && st_q.beat == '0 && st_q.active));

    // R7
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.active && cmd != CMD_LOAD) |=> ($stable(st_q.beat) && !st_q.active));
endmodule

// File: rtl/burst_order.sv
module burst_order #(
    parameter int BURST_W = 2
) (
    input  logic [BURST_W-1:0] base_lo,
    input  logic [BURST_W-1:0] beat,
    input  logic               interleave,
    output logic [BURST_W-1:0] lo_o
);
    logic [BURST_W-1:0] lin_lo;
    logic [BURST_W-1:0] xor_lo;

    assign lin_lo = base_lo + beat;

    for (genvar b = 0; b < BURST_W; b++) begin : g_xor
        assign xor_lo[b] = base_lo[b] ^ beat[b];
    end

    assign lo_o = interleave ? xor_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              load,
    input  logic              desel,
    input  logic              adv,
    input  logic              lin_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - BURST_W;

    burst_cmd_e         cmd;
    logic [ADDR_W-1:0]  base;
    logic [BURST_W-1:0] beat;
    logic               active;
    logic [BURST_W-1:0] lo;

    burst_cmd_dec u_dec (
        .ce_n   (ce_n),
        .load   (load),
        .desel  (desel),
        .adv    (adv),
        .active (active),
        .cmd    (cmd)
    );

    burst_state #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ext_addr (ext_addr),
        .base_o   (base),
        .beat_o   (beat),
        .active_o (active)
    );

    burst_order #(.BURST_W(BURST_W)) u_order (
        .base_lo    (base[BURST_W-1:0]),
        .beat       (beat),
        .interleave (lin_n),
        .lo_o       (lo)
    );

    assign addr_o = {base[ADDR_W-1:BURST_W], lo};

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !load && !desel && adv && active && !lin_n) |=>
        (lin_n || addr_o[BURST_W-1:0] == BURST_W'($past(addr_o[BURST_W-1:0]) + 1'b1)));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> (addr_o[ADDR_W-1:BURST_W] == $past(addr_o[ADDR_W-1:BURST_W])));

    initial begin
        // R3
        hi_width_chk: assert (HI_W > 0);
    end
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b0, load = 1'b0, desel = 1'b0, adv = 1'b0, lin_n = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .load(load), .desel(desel),
        .adv(adv), .lin_n(lin_n), .ext_addr(ext_addr), .addr_o(addr_o)
    );

    // {req[3:0], ce_n, load, desel, adv, lin_n, ext[7:0], exp[7:0]}
    localparam int NV = 26;
    localparam logic [24:0] VEC [0:NV-1] = '{
        {4'd2, 5'b01000, 8'hA6, 8'hA6},  // R2 load
        {4'd3, 5'b00010, 8'h00, 8'hA7},  // R3
        {4'd3, 5'b00010, 8'h00, 8'hA4},  // R3 wrap, no carry
        {4'd3, 5'b00010, 8'h00, 8'hA5},  // R3
        {4'd5, 5'b00010, 8'h00, 8'hA6},  // R5 back to start
        {4'd5, 5'b00010, 8'h00, 8'hA7},  // R5 repeat
        {4'd6, 5'b10010, 8'h00, 8'hA7},  // R6 stall advance
        {4'd6, 5'b11000, 8'h33, 8'hA7},  // R6 stall load
        {4'd3, 5'b00010, 8'h00, 8'hA4},  // R3 after stall
        {4'd2, 5'b01001, 8'h3D, 8'h3D},  // R2 load interleaved
        {4'd4, 5'b00011, 8'h00, 8'h3C},  // R4 01^01
        {4'd4, 5'b00011, 8'h00, 8'h3F},  // R4 01^10
        {4'd4, 5'b00011, 8'h00, 8'h3E},  // R4 01^11
        {4'd5, 5'b00011, 8'h00, 8'h3D},  // R5 wrap interleaved
        {4'd2, 5'b01001, 8'h72, 8'h72},  // R2
        {4'd4, 5'b00011, 8'h00, 8'h73},  // R4 10^01
        {4'd4, 5'b00011, 8'h00, 8'h70},  // R4 10^10
        {4'd4, 5'b00011, 8'h00, 8'h71},  // R4 10^11
        {4'd7, 5'b00101, 8'h00, 8'h71},  // R7 deselect keeps address
        {4'd7, 5'b00011, 8'h00, 8'h71},  // R7 continue while deselected
        {4'd7, 5'b00011, 8'h00, 8'h71},  // R7
        {4'd8, 5'b01000, 8'hFF, 8'hFF},  // R8 new burst
        {4'd3, 5'b00010, 8'h00, 8'hFC},  // R3 11->00, upper kept
        {4'd3, 5'b00010, 8'h00, 8'hFD},  // R3
        {4'd8, 5'b01000, 8'h10, 8'h10},  // R8 mid-burst reload
        {4'd8, 5'b00010, 8'h00, 8'h11}   // R8 beat restarted at 0
    };

    task automatic check(input int req, input logic [AW-1:0] exp);
        tests++;
        if (addr_o !== exp) begin
            fails++;
            $display("FAIL R%0d: addr_o=%h expected %h", req, addr_o, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(1, 8'h00);
        rst_n = 1'b1;
        adv   = 1'b1;
        @(negedge clk);
        check(1, 8'h00);            // R1 continue before any load has no effect (R7)
        @(negedge clk);
        check(7, 8'h00);

        for (int i = 0; i < NV; i++) begin
            {ce_n, load, desel, adv, lin_n} = VEC[i][20:16];
            ext_addr = VEC[i][15:8];
            @(negedge clk);
            check(int'(VEC[i][24:21]), VEC[i][7:0]);
        end

        // R6: stall across a deselect leaves burst running
        {ce_n, load, desel, adv, lin_n} = 5'b10100;
        @(negedge clk);
        {ce_n, load, desel, adv, lin_n} = 5'b00010;
        @(negedge clk);
        check(6, 8'h12);

        // R1: reset in mid-burst clears the address
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 8'h00);

        finish_run();
    end
endmodule